// File: doc/BRIEF.md
# Bus Watchpoint Trigger Monitor

This block watches transactions on an internal bus and emits trigger pulses when a programmed event occurs. A bus transaction qualifies when its address matches under a per-bit compare mask and its transaction type is one of the selected types. Type matching can also be turned off. Extra conditions can be required at the same time: an external trigger input, a trace-buffer event, a performance-counter overflow, or a match of the current context ID against a programmed value.

The monitor runs a small sequence: IDLE, then ARMED, then FIRED. Arming is caused by any of a selectable set of arm sources. If no arm source is selected, the monitor arms on its own once enabled. Every qualifying transaction produces a one-cycle pulse on the external trigger pin and on the performance-counter event output. The trace-buffer trigger strobe fires only on the first trigger after arming. A sticky hit flag records that a trigger happened. Software clears it by writing 1.

Software programs the monitor through a write-only register port with no wait states. Because the overflow input can act as a trigger source, a chain can be built that runs from watchpoint hit, to counter increment, to overflow, to the start of a trace.

Top module: `bus_watch_trig`

## Requirements
- R1: After reset the monitor is disabled. While control bit 0 (enable) is 0, ext_trig_out, pm_event_out, tb_trig_out and tb_arm_out stay 0 and mon_armed is 0.
- R2: A transaction's address hits when ((bus_addr XOR addr register) AND mask register) is zero. A mask bit of 1 compares that address bit, so an all-zero mask (the reset value) hits on every address.
- R3: Bit k of the type mask register lets type index k (bus_type = k) match. The mask resets to zero, and an all-zero mask matches no type.
- R4: With only enable set and all other registers at their reset values, no transaction ever produces a trigger.
- R5: Control bit 1 (type-check bypass, reset 0) set to 1 skips the type check entirely.
- R6: Control bits 9:6 select trigger qualifiers: bit 6 ext_trig_in, bit 7 tb_event_in, bit 8 pm_ovf_in, bit 9 context match (ctx_id equal to the context register). Every selected qualifier must be true in the transaction's cycle.
- R7: Control bits 5:2 select arm sources in the same order (bit 2 external, bit 3 trace event, bit 4 overflow, bit 5 context match). While IDLE and enabled, any selected source being true moves the monitor to ARMED one cycle later. With no arm source selected, it arms one cycle after enable is visible. Entering ARMED gives a one-cycle tb_arm_out pulse. In IDLE, transactions produce no trigger.
- R8: Each qualifying transaction while armed raises ext_trig_out and pm_event_out for exactly one cycle, in the cycle after bus_valid. tb_trig_out pulses only for the first such trigger, after which the monitor is FIRED.
- R9: hit_sticky is set by every trigger and is cleared by writing 1 to bit 0 of offset 5. Writing 0 leaves it unchanged. A trigger in the same cycle as the clear wins.
- R10: Register offsets are 0 control, 1 address, 2 address mask, 3 type mask, 4 context. A write becomes effective for transactions from the next cycle. A transaction in the same cycle as the write is compared with the old values.
- R11: Clearing enable returns the monitor to IDLE one cycle later, and it then produces no triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register offset |
| reg_wr_data | input | DW | Register write data |
| bus_valid | input | 1 | Bus transaction valid |
| bus_addr | input | AW | Transaction address |
| bus_type | input | $clog2(NT) | Transaction type index |
| ctx_id | input | CW | Current context ID |
| ext_trig_in | input | 1 | External trigger input |
| tb_event_in | input | 1 | Trace-buffer event input |
| pm_ovf_in | input | 1 | Performance-counter overflow input |
| ext_trig_out | output | 1 | External trigger pin, one cycle per trigger |
| pm_event_out | output | 1 | Countable event pulse per trigger |
| tb_arm_out | output | 1 | Trace-buffer arm strobe |
| tb_trig_out | output | 1 | Trace-buffer trigger strobe, first trigger only |
| hit_sticky | output | 1 | Sticky trigger flag, write-1-to-clear |
| mon_armed | output | 1 | Monitor is ARMED or FIRED |

## Verification
Two actions can land in the same clock cycle: a register write and a bus transaction. The bench rewrites the address register in exactly the cycle that a transaction arrives carrying the old address, and expects that transaction to trigger under the old value. The next transaction must then follow the new value. The bench also issues a sticky-clear write in the same cycle as a qualifying transaction and expects the flag to remain set.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_FIRED = 2'd2
  } mon_state_e;

  localparam int SRC_N = 4;

  // control register layout, bit 0 at the bottom
  typedef struct packed {
    logic [SRC_N-1:0] trig_sel; // 9:6
    logic [SRC_N-1:0] arm_sel;  // 5:2
    logic             tmd;      // 1
    logic             en;       // 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [2:0] OFS_CTRL   = 3'd0;
  localparam logic [2:0] OFS_ADDR   = 3'd1;
  localparam logic [2:0] OFS_AMASK  = 3'd2;
  localparam logic [2:0] OFS_TMASK  = 3'd3;
  localparam logic [2:0] OFS_CTX    = 3'd4;
  localparam logic [2:0] OFS_STATUS = 3'd5;
endpackage

// File: rtl/bwt_regs.sv
module bwt_regs
  import bwt_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NT = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output ctrl_t         ctrl,
  output logic [AW-1:0] wm_addr,
  output logic [AW-1:0] wm_amask,
  output logic [NT-1:0] wm_tmask,
  output logic [CW-1:0] wm_ctx,
  output logic          sticky_clr
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      wm_addr  <= '0;
      wm_amask <= '0;
      wm_tmask <= '0;
      wm_ctx   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        OFS_CTRL:  ctrl     <= ctrl_t'(wr_data[CTRL_W-1:0]);
        OFS_ADDR:  wm_addr  <= wr_data[AW-1:0];
        OFS_AMASK: wm_amask <= wr_data[AW-1:0];
        OFS_TMASK: wm_tmask <= wr_data[NT-1:0];
        OFS_CTX:   wm_ctx   <= wr_data[CW-1:0];
        default: ;
      endcase
    end
  end

  assign sticky_clr = wr_en && (wr_addr == OFS_STATUS) && wr_data[0];
endmodule

// File: rtl/bwt_match.sv
module bwt_match
  import bwt_pkg::*;
#(
  parameter int AW  = 32,
  parameter int NT  = 8,
  parameter int CW  = 8,
  localparam int TIW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic [AW-1:0]    bus_addr,
  input  logic [TIW-1:0]   bus_type,
  input  logic [CW-1:0]    ctx_id,
  input  logic             ext_trig_in,
  input  logic             tb_event_in,
  input  logic             pm_ovf_in,
  input  ctrl_t            ctrl,
  input  logic [AW-1:0]    wm_addr,
  input  logic [AW-1:0]    wm_amask,
  input  logic [NT-1:0]    wm_tmask,
  input  logic [CW-1:0]    wm_ctx,
  output logic             addr_hit,
  output logic             type_hit,
  output logic [SRC_N-1:0] src_vec
);
  function automatic logic f_addr_hit(input logic [AW-1:0] a, input logic [AW-1:0] ref_a,
                                      input logic [AW-1:0] msk);
    return ((a ^ ref_a) & msk) == '0;
  endfunction

  function automatic logic f_type_hit(input logic [TIW-1:0] t, input logic [NT-1:0] msk,
                                      input logic bypass);
    return bypass || msk[t];
  endfunction

  assign addr_hit = f_addr_hit(bus_addr, wm_addr, wm_amask);
  assign type_hit = f_type_hit(bus_type, wm_tmask, ctrl.tmd);
  assign src_vec  = {(ctx_id == wm_ctx), pm_ovf_in, tb_event_in, ext_trig_in};
endmodule

// File: rtl/bwt_seq.sv
module bwt_seq
  import bwt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic             bus_valid,
  input  logic             addr_hit,
  input  logic             type_hit,
  input  logic [SRC_N-1:0] src_vec,
  input  logic             sticky_clr,
  output logic             ext_trig_out,
  output logic             pm_event_out,
  output logic             tb_arm_out,
  output logic             tb_trig_out,
  output logic             hit_sticky,
  output logic             mon_armed
);
  mon_state_e state, state_nx;
  logic arm_cond, trig_src_ok, qual, arm_now;

  assign arm_cond    = (ctrl.arm_sel == '0) || |(ctrl.arm_sel & src_vec);
  assign trig_src_ok = &(~ctrl.trig_sel | src_vec);
  assign qual        = ctrl.en && (state != ST_IDLE) && bus_valid && addr_hit && type_hit
                       && trig_src_ok;
  assign arm_now     = ctrl.en && (state == ST_IDLE) && arm_cond;

  always_comb begin
    state_nx = state;
    if (!ctrl.en) state_nx = ST_IDLE;
    else begin
      case (state)
        ST_IDLE:  if (arm_cond) state_nx = ST_ARMED;
        ST_ARMED: if (qual) state_nx = ST_FIRED;
        default:  state_nx = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      ext_trig_out <= 1'b0;
      pm_event_out <= 1'b0;
      tb_arm_out   <= 1'b0;
      tb_trig_out  <= 1'b0;
      hit_sticky   <= 1'b0;
    end else begin
      state        <= state_nx;
      ext_trig_out <= qual;
      pm_event_out <= qual;
      tb_arm_out   <= arm_now;
      tb_trig_out  <= qual && (state == ST_ARMED);
      hit_sticky   <= qual || (hit_sticky && !sticky_clr);
    end
  end

  assign mon_armed = (state != ST_IDLE);

  AST_OFF_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |=> !ext_trig_out); // R1
  AST_TRIG_NEEDS_TXN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_trig_out) |-> $past(bus_valid)); // R8
  AST_TB_TRIG_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    tb_trig_out |=> !tb_trig_out); // R8
  AST_ARM_STROBE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    tb_arm_out |-> mon_armed); // R7
  AST_STICKY_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    ext_trig_out |-> hit_sticky); // R9
endmodule

// File: rtl/bus_watch_trig.sv
module bus_watch_trig
  import bwt_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int NT  = 8,
  parameter int CW  = 8,
  localparam int TIW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr_en,
  input  logic [2:0]     reg_wr_addr,
  input  logic [DW-1:0]  reg_wr_data,
  input  logic           bus_valid,
  input  logic [AW-1:0]  bus_addr,
  input  logic [TIW-1:0] bus_type,
  input  logic [CW-1:0]  ctx_id,
  input  logic           ext_trig_in,
  input  logic           tb_event_in,
  input  logic           pm_ovf_in,
  output logic           ext_trig_out,
  output logic           pm_event_out,
  output logic           tb_arm_out,
  output logic           tb_trig_out,
  output logic           hit_sticky,
  output logic           mon_armed
);
  ctrl_t            ctrl;
  logic [AW-1:0]    wm_addr, wm_amask;
  logic [NT-1:0]    wm_tmask;
  logic [CW-1:0]    wm_ctx;
  logic             sticky_clr, addr_hit, type_hit;
  logic [SRC_N-1:0] src_vec;

  bwt_regs #(.AW(AW), .DW(DW), .NT(NT), .CW(CW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
    .wr_data(reg_wr_data), .ctrl(ctrl), .wm_addr(wm_addr), .wm_amask(wm_amask),
    .wm_tmask(wm_tmask), .wm_ctx(wm_ctx), .sticky_clr(sticky_clr)
  );

  bwt_match #(.AW(AW), .NT(NT), .CW(CW)) match_i (
    .bus_addr(bus_addr), .bus_type(bus_type), .ctx_id(ctx_id),
    .ext_trig_in(ext_trig_in), .tb_event_in(tb_event_in), .pm_ovf_in(pm_ovf_in),
    .ctrl(ctrl), .wm_addr(wm_addr), .wm_amask(wm_amask), .wm_tmask(wm_tmask),
    .wm_ctx(wm_ctx), .addr_hit(addr_hit), .type_hit(type_hit), .src_vec(src_vec)
  );

  bwt_seq seq_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .bus_valid(bus_valid),
    .addr_hit(addr_hit), .type_hit(type_hit), .src_vec(src_vec),
    .sticky_clr(sticky_clr), .ext_trig_out(ext_trig_out), .pm_event_out(pm_event_out),
    .tb_arm_out(tb_arm_out), .tb_trig_out(tb_trig_out), .hit_sticky(hit_sticky),
    .mon_armed(mon_armed)
  );

  AST_ZERO_AMASK_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (wm_amask == '0) |-> addr_hit); // R2
  AST_ZERO_TMASK_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wm_tmask == '0 && !ctrl.tmd) |-> !type_hit); // R3
  AST_BYPASS_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.tmd |-> type_hit); // R5
endmodule

// File: tb/bus_watch_trig_tb_top.sv
module bus_watch_trig_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [2:0]  bus_type = '0;
  logic [7:0]  ctx_id = '0;
  logic        ext_trig_in = 1'b0, tb_event_in = 1'b0, pm_ovf_in = 1'b0;
  logic        ext_trig_out, pm_event_out, tb_arm_out, tb_trig_out, hit_sticky, mon_armed;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_watch_trig dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_type(bus_type), .ctx_id(ctx_id), .ext_trig_in(ext_trig_in),
    .tb_event_in(tb_event_in), .pm_ovf_in(pm_ovf_in), .ext_trig_out(ext_trig_out),
    .pm_event_out(pm_event_out), .tb_arm_out(tb_arm_out), .tb_trig_out(tb_trig_out),
    .hit_sticky(hit_sticky), .mon_armed(mon_armed)
  );

  // {address, type, expected trigger}
  localparam logic [35:0] VEC [8] = '{
    {32'h1000_0040, 3'd0, 1'b1},
    {32'h1000_004F, 3'd2, 1'b1},
    {32'h1000_0050, 3'd0, 1'b0},
    {32'h1000_0040, 3'd1, 1'b0},
    {32'h9000_0044, 3'd2, 1'b0},
    {32'h1000_0041, 3'd3, 1'b0},
    {32'h1000_004C, 3'd0, 1'b1},
    {32'h0000_0040, 3'd0, 1'b0}
  };

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic txn(input logic [31:0] a, input logic [2:0] t);
    bus_valid = 1'b1; bus_addr = a; bus_type = t;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int tb_trig_count;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(ext_trig_out, 1'b0, "R1 ext after reset");
    chk(mon_armed, 1'b0, "R1 armed after reset");
    chk(hit_sticky, 1'b0, "R9 sticky after reset");
    txn(32'h0, 3'd0);
    chk(ext_trig_out, 1'b0, "R1 disabled txn");
    // R4 enable alone never triggers
    wr(3'd0, 32'h1);
    @(negedge clk);
    chk(tb_arm_out, 1'b1, "R7 self-arm strobe");
    chk(mon_armed, 1'b1, "R7 self-armed");
    txn(32'h1234_5678, 3'd0);
    chk(ext_trig_out, 1'b0, "R4 defaults no trigger");
    // R5 bypass type check, zero addr mask hits all (R2)
    wr(3'd0, 32'h3);
    txn(32'hDEAD_BEEF, 3'd5);
    chk(ext_trig_out, 1'b1, "R5 bypass with zero mask R2");

    // table walk: R2, R3, R8
    do_reset();
    wr(3'd1, 32'h1000_0040);
    wr(3'd2, 32'hFFFF_FFF0);
    wr(3'd3, 32'h0000_0005);
    wr(3'd0, 32'h1);
    @(negedge clk);
    tb_trig_count = 0;
    for (int i = 0; i < 8; i++) begin
      txn(VEC[i][35:4], VEC[i][3:1]);
      chk(ext_trig_out, VEC[i][0], $sformatf("R2 R3 vector %0d", i));
      chk(pm_event_out, VEC[i][0], $sformatf("R8 pm event vector %0d", i));
      if (tb_trig_out) tb_trig_count++;
    end
    checks++;
    if (tb_trig_count != 1) begin
      failures++;
      $display("FAIL R8 tb_trig count actual=%0d expected=1", tb_trig_count);
    end
    @(negedge clk);
    chk(ext_trig_out, 1'b0, "R8 pulse one cycle");

    // R9 sticky
    chk(hit_sticky, 1'b1, "R9 sticky set");
    wr(3'd5, 32'h0);
    chk(hit_sticky, 1'b1, "R9 write 0 keeps");
    wr(3'd5, 32'h1);
    chk(hit_sticky, 1'b0, "R9 write 1 clears");
    reg_wr_en = 1'b1; reg_wr_addr = 3'd5; reg_wr_data = 32'h1;
    txn(32'h1000_0040, 3'd0);
    reg_wr_en = 1'b0;
    chk(hit_sticky, 1'b1, "R9 set wins over clear");

    // R10 same-cycle write and transaction
    reg_wr_en = 1'b1; reg_wr_addr = 3'd1; reg_wr_data = 32'h2000_0000;
    txn(32'h1000_0040, 3'd0);
    reg_wr_en = 1'b0;
    chk(ext_trig_out, 1'b1, "R10 old address used");
    txn(32'h1000_0040, 3'd0);
    chk(ext_trig_out, 1'b0, "R10 old address gone");
    txn(32'h2000_0008, 3'd2);
    chk(ext_trig_out, 1'b1, "R10 new address");

    // R11 disable
    wr(3'd0, 32'h0);
    @(negedge clk);
    chk(mon_armed, 1'b0, "R11 back to idle");
    txn(32'h2000_0000, 3'd0);
    chk(ext_trig_out, 1'b0, "R11 no trigger idle");

    // R6 trigger qualifiers
    do_reset();
    wr(3'd0, 32'h043);
    @(negedge clk);
    txn(32'h100, 3'd0);
    chk(ext_trig_out, 1'b0, "R6 ext qualifier low");
    ext_trig_in = 1'b1;
    txn(32'h100, 3'd0);
    ext_trig_in = 1'b0;
    chk(ext_trig_out, 1'b1, "R6 ext qualifier high");
    chk(tb_trig_out, 1'b1, "R8 first trigger strobe");
    wr(3'd0, 32'h103);
    txn(32'h100, 3'd0);
    chk(ext_trig_out, 1'b0, "R6 overflow low");
    pm_ovf_in = 1'b1;
    txn(32'h100, 3'd0);
    pm_ovf_in = 1'b0;
    chk(ext_trig_out, 1'b1, "R6 overflow high");
    chk(tb_trig_out, 1'b0, "R8 no second strobe");
    wr(3'd4, 32'h5A);
    wr(3'd0, 32'h203);
    ctx_id = 8'h5A;
    txn(32'h100, 3'd0);
    chk(ext_trig_out, 1'b1, "R6 context match");
    ctx_id = 8'h5B;
    txn(32'h100, 3'd0);
    chk(ext_trig_out, 1'b0, "R6 context mismatch");
    wr(3'd0, 32'h243);
    ctx_id = 8'h5A;
    txn(32'h100, 3'd0);
    chk(ext_trig_out, 1'b0, "R6 all selected required");

    // R7 arm stage from trace event
    do_reset();
    wr(3'd0, 32'h00B);
    repeat (2) @(negedge clk);
    chk(mon_armed, 1'b0, "R7 waits for arm source");
    txn(32'h100, 3'd0);
    chk(ext_trig_out, 1'b0, "R7 no trigger while idle");
    tb_event_in = 1'b1;
    @(negedge clk);
    tb_event_in = 1'b0;
    chk(tb_arm_out, 1'b1, "R7 arm strobe");
    chk(mon_armed, 1'b1, "R7 armed");
    @(negedge clk);
    chk(tb_arm_out, 1'b0, "R7 arm strobe one cycle");
    txn(32'h100, 3'd0);
    chk(ext_trig_out, 1'b1, "R7 trigger after arm");
    chk(tb_trig_out, 1'b1, "R8 trace trigger after arm");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule